// File: doc/BRIEF.md
# Stereo Overload Detector with Retriggerable Hold

This block watches a stereo stream of signed samples and raises a status flag when either channel comes close to full scale. A sample counts as an overload when its magnitude is above a fixed threshold of 0.8748 of full scale, which is about 1.16 dB below the full digital swing. The threshold is computed from the sample width.

The flag is meant for a status register that software reads. It is held high long enough to be seen by slow polling. Every overload reloads a hold counter to a set number of sample periods. The counter counts down only on sample strobes. The flag drops when the counter runs out, so it stays high for at least the hold time after the last overload.

Samples are valid only in a cycle where the strobe is high. The sample-rate timebase is the strobe itself, so the hold time is the same number of samples at any sample rate.

Top module: `ovl_detect`

## Requirements
- R1: After a synchronous reset, `ovl_flag` is 0 and the hold counter is empty. With quiet input, the flag stays 0.
- R2: For 24-bit samples the threshold T is 7338354, which is 0.8748 × 2^23 rounded. A positive sample equal to T is not an overload. A positive sample of T+1 is an overload.
- R3: Negative samples are compared by magnitude. -T is not an overload. -(T+1) is an overload.
- R4: The most negative code, -8388608, is an overload.
- R5: An overload on either channel alone sets the flag. An overload on both channels in the same strobe also sets it.
- R6: `ovl_flag` is 1 in the clock cycle after the strobed sample that overloads.
- R7: After the last overload, the flag stays 1 through the next HOLD_SAMPLES-1 strobes (default 512). It returns to 0 in the cycle after the HOLD_SAMPLES-th strobe.
- R8: An overload while the flag is held restarts the full hold time. This includes an overload on the strobe where the hold would otherwise expire.
- R9: Cycles without a strobe are ignored. Their sample values set nothing, and they do not advance the hold countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe; the samples are valid when this is high |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| ovl_flag | output | 1 | Overload status, held for the hold time |

## Verification
Two functions can act on the same strobe: the countdown that ends the hold, and a fresh overload that reloads it.

The bench provokes this in two steps. It lets exactly HOLD_SAMPLES-1 quiet strobes pass after an overload. It then sends an overload on the strobe that would otherwise clear the flag.

The reload must win. The bench checks that the flag shows no one-cycle dip in the cycle after that strobe. It also checks that the following countdown is a full HOLD_SAMPLES strobes long, measured from the late overload. A second case hits both channels on the same strobe and checks that the hold loads once.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    // Overload threshold: 0.8748 of 2^(w-1), rounded to nearest
    function automatic longint thr_code(input int w);
        return ((longint'(1) << (w - 1)) * 8748 + 5000) / 10000;
    endfunction

    // Per-channel overload indications
    typedef struct packed {
        logic left;
        logic right;
    } ovl_hit_t;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_HELD  = 1'b1
    } ovl_state_e;

endpackage

// File: rtl/ovl_mag_cmp.sv
module ovl_mag_cmp #(
    parameter int SAMPLE_W = 24,
    parameter logic [SAMPLE_W-1:0] THR = '0
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic                       over
);
    logic [SAMPLE_W-1:0] mag;

    // Magnitude in unsigned W bits; the most negative code maps to 2^(W-1)
    always_comb begin
        if (sample[SAMPLE_W-1])
            mag = (~$unsigned(sample)) + 1'b1;
        else
            mag = $unsigned(sample);
        over = (mag > THR);
    end
endmodule

// File: rtl/ovl_hold_timer.sv
module ovl_hold_timer
    import ovl_pkg::*;
#(
    parameter int HOLD_SAMPLES = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic hit,
    output logic flag
);
    localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_SAMPLES);

    logic [CNT_W-1:0] cnt;
    ovl_state_e       state;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            state <= ST_CLEAR;
        end else if (strobe) begin
            if (hit) begin
                cnt   <= HOLD_LD;
                state <= ST_HELD;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1))
                    state <= ST_CLEAR;
            end
        end
    end

    assign flag = (state == ST_HELD);

    AST_RISE_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        strobe && hit |=> flag);                                   // R6
    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (rst)
        strobe && hit |=> cnt == HOLD_LD);                         // R8
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(cnt) && $stable(flag));                // R9
    AST_FALL_ON_STB: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(strobe) && !$past(hit));             // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= HOLD_LD);                                           // R7
endmodule

// File: rtl/ovl_detect.sv
module ovl_detect
    import ovl_pkg::*;
#(
    parameter int SAMPLE_W     = 24,
    parameter int HOLD_SAMPLES = 512
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_stb,
    input  logic signed [SAMPLE_W-1:0] smp_left,
    input  logic signed [SAMPLE_W-1:0] smp_right,
    output logic                       ovl_flag
);
    localparam longint THR_L = thr_code(SAMPLE_W);
    localparam logic [SAMPLE_W-1:0] THR = SAMPLE_W'(THR_L);
    localparam logic signed [SAMPLE_W-1:0] MOST_NEG =
        {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [SAMPLE_W-1:0] ch_smp [2];
    logic [1:0]                 ch_over;
    ovl_hit_t                   hits;
    logic                       any_hit;

    assign ch_smp[0] = smp_left;
    assign ch_smp[1] = smp_right;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        ovl_mag_cmp #(
            .SAMPLE_W (SAMPLE_W),
            .THR      (THR)
        ) u_cmp (
            .sample (ch_smp[c]),
            .over   (ch_over[c])
        );
    end

    assign hits    = '{left: ch_over[0], right: ch_over[1]};
    assign any_hit = hits.left | hits.right;

    ovl_hold_timer #(
        .HOLD_SAMPLES (HOLD_SAMPLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .strobe (smp_stb),
        .hit    (any_hit),
        .flag   (ovl_flag)
    );

    AST_MOST_NEG_TRIPS: assert property (@(posedge clk) disable iff (rst)
        smp_stb && (smp_left == MOST_NEG || smp_right == MOST_NEG)
        |=> ovl_flag);                                             // R4
    AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        smp_stb && !ovl_flag
        && smp_left  == $signed(THR) && smp_right == -$signed(THR)
        |=> !ovl_flag);                                            // R2
endmodule

// File: tb/ovl_detect_tb.sv
module ovl_detect_tb;
    localparam int W    = 24;
    localparam int HOLD = 512;
    localparam int T    = 7338354;
    localparam int MAXP = 8388607;
    localparam int MINN = -8388608;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb = 1'b0;
    logic signed [W-1:0] sl = '0;
    logic signed [W-1:0] sr = '0;
    logic flag;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit q_exp[$];
    string q_tag[$];

    always #2 clk = ~clk;

    ovl_detect #(.SAMPLE_W(W), .HOLD_SAMPLES(HOLD)) u_dut (
        .clk(clk), .rst(rst), .smp_stb(stb),
        .smp_left(sl), .smp_right(sr), .ovl_flag(flag)
    );

    function automatic bit over_ref(input int v);
        longint a;
        a = (v < 0) ? -longint'(v) : longint'(v);
        return a > T;
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flag=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one strobed sample, expected result pushed to the scoreboard
    task automatic send(input int l, input int r, input string tag, input int gap);
        @(negedge clk);
        sl  = l[W-1:0];
        sr  = r[W-1:0];
        stb = 1'b1;
        if (over_ref(l) || over_ref(r)) ref_cnt = HOLD;
        else if (ref_cnt > 0) ref_cnt--;
        q_exp.push_back(ref_cnt > 0);
        q_tag.push_back(tag);
        @(negedge clk);
        stb = 1'b0;
        sl  = '0;
        sr  = '0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) send(i * 37 - 500, 1000 - i, tag, i % 3);
    endtask

    // Monitor: each strobed edge produces one result, sampled after the edge
    initial begin
        forever begin
            @(posedge clk);
            if (stb && !rst) begin
                #1;
                if (q_exp.size() > 0) check(flag, q_exp.pop_front(), q_tag.pop_front());
            end
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: flag=%0b expected=finish", flag);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(flag, 1'b0, "R1 reset");
        rst = 1'b0;
        quiet(4, "R1 quiet");

        send(T, 0, "R2 equal T", 1);
        send(T + 1, 0, "R2 T+1 / R6 rise", 0);
        quiet(HOLD - 1, "R7 held");
        send(5, 5, "R7 expiry", 1);
        send(0, -T, "R3 minus T", 0);
        send(0, -(T + 1), "R3 minus T+1", 0);
        quiet(300, "R8 pre");
        send(MINN, 0, "R4 most negative", 2);
        quiet(HOLD - 1, "R8 restarted hold");
        send(0, MAXP, "R8 hit on expiry strobe / R5 right", 0);
        quiet(HOLD - 1, "R8 full hold again");
        send(1, 1, "R8 expiry after reload", 0);

        send(MINN, MAXP, "R5 both channels", 0);
        quiet(HOLD, "R5 hold both");

        // R9: unstrobed overload values must not set the flag
        @(negedge clk);
        sl = MAXP[W-1:0];
        sr = MINN[W-1:0];
        repeat (5) @(negedge clk);
        check(flag, 1'b0, "R9 no strobe");
        sl = '0;
        sr = '0;

        // R9: unstrobed cycles do not advance the countdown
        send(T + 1, 0, "R9 load", 0);
        quiet(HOLD - 2, "R9 hold");
        repeat (40) @(negedge clk);
        check(flag, 1'b1, "R9 idle keeps hold");
        send(0, 0, "R9 last held", 0);
        send(0, 0, "R9 expiry", 2);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule